// File: doc/BRIEF.md
# Indirect interrupt redirection register file

This block holds the configuration of an interrupt router. Software sees only two 32-bit locations: a select register that picks an internal register, and a data window that reads or writes the picked register. Behind the window are four kinds of register. The first is an identification byte. The second is a read-only version word. The third is a placeholder that always reads zero. The rest is a table of 64-bit redirection entries, one per interrupt input. Each entry is reached as two 32-bit halves.

The whole table is driven out in parallel to a neighbouring delivery engine. A one-cycle update strobe tells that engine to re-scan its pending requests after software has touched any entry. Some low-half writes carry a vector outside the legal range. When the write also leaves the entry unmasked, the block drops it and the entry keeps its previous contents. This guards against software that writes an all-zero low half.

Top module: `irq_route_regfile`

## Requirements
- R1: Only bus address bits 7:0 are decoded. Offset 0x00 is the select register, which reads back its 8-bit value in bits 7:0. Offset 0x10 is the data window. Every other offset reads 0, and a write to it changes nothing.
- R2: Select value 0x00 reaches the identification register. It reads with the ID in bits 31:24 and zeros elsewhere. A write keeps only bits 31:24 of the data.
- R3: Select value 0x01 reads 0x00170011 with the default 24 entries: 0x11 in bits 7:0 and the highest entry index in bits 23:16. Writes to it change nothing.
- R4: Select value 0x02 always reads 0, and writes to it change nothing.
- R5: A select value s ≥ 0x10 reaches entry (s−0x10)/2. An odd s reaches bits 63:32 and an even s reaches bits 31:0. A select value beyond the last entry reads 0, and so do values 0x03 to 0x0F. Writes through the window at such a select value change nothing.
- R6: A low-half write is stored only in two cases: bit 16 (mask) of the data is 1, or bits 7:0 (vector) lie in 0x10..0xFE. Any other low-half write leaves the entry unchanged.
- R7: A high-half write is always stored.
- R8: After reset, every entry is 0x0000_0000_0001_0000 and the select register is 0. The ID equals the CPU_COUNT parameter, which defaults to 1.
- R9: Every window write that reaches a valid entry half raises `ent_upd` for exactly the following cycle. This includes a low-half write that R6 rejects. No other write raises it.
- R10: Entry i appears on `tbl_flat[64*i+63 : 64*i]` from the cycle after the write that stored it.
- R11: Read data depends combinationally on the address and the current select value. A select write takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (32) | Byte address; only bits 7:0 decoded |
| bus_we | input | 1 | Write enable for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| tbl_flat | output | 64*NUM_ENT (1536) | All redirection entries, entry 0 in the low bits |
| ent_upd | output | 1 | One-cycle pulse after any entry-half write |

## Verification
The assertions run on every cycle. They check the reset values of the select register and the table. They check that a filtered low-half write, a write at an out-of-range select value and a write at an undecoded offset leave the table stable. They check that a high-half write lands in the addressed entry, and that the update strobe only follows a write to a valid entry half. The bench scenarios are needed for the rest: the exact read words for the ID, version and placeholder registers, and the mapping of select values to entry halves at the first and last entries. They also cover the edges of the legal vector range (0x0F, 0x10, 0xFE, 0xFF) and the masked-write exemption, and confirm that address bits above 7 are ignored.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam int          WORD_W      = 32;
  localparam int          ENT_W       = 64;
  localparam logic [7:0]  OFF_SEL     = 8'h00;
  localparam logic [7:0]  OFF_WIN     = 8'h10;
  localparam logic [7:0]  SEL_ID      = 8'h00;
  localparam logic [7:0]  SEL_VER     = 8'h01;
  localparam logic [7:0]  SEL_ARB     = 8'h02;
  localparam logic [7:0]  SEL_TBL     = 8'h10;
  localparam logic [7:0]  VER_CODE    = 8'h11;
  localparam int          MASK_BIT    = 16;
  localparam logic [63:0] ENT_RESET   = 64'h0000_0000_0001_0000;

  // Legal vector range for an unmasked entry
  function automatic logic vec_legal(input logic [7:0] v);
    return (v >= 8'h10) && (v != 8'hFF);
  endfunction
endpackage

// File: rtl/irt_decode.sv
module irt_decode
  import irt_pkg::*;
#(
  parameter int NUM_ENT = 24,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic [7:0]       addr,
  input  logic [7:0]       sel,
  output logic             hit_sel,
  output logic             hit_win,
  output logic             is_id,
  output logic             is_ver,
  output logic             is_arb,
  output logic             ent_hit,
  output logic             ent_hi,
  output logic [IDX_W-1:0] ent_idx
);
  logic [7:0] off;
  logic [6:0] pair;

  always_comb begin
    hit_sel = (addr == OFF_SEL);
    hit_win = (addr == OFF_WIN);
    is_id   = (sel == SEL_ID);
    is_ver  = (sel == SEL_VER);
    is_arb  = (sel == SEL_ARB);
    off     = sel - SEL_TBL;
    pair    = off[7:1];
    ent_hi  = off[0];
    ent_hit = (sel >= SEL_TBL) && (pair < 7'(NUM_ENT));
    ent_idx = pair[IDX_W-1:0];
  end
endmodule

// File: rtl/irt_table.sv
module irt_table
  import irt_pkg::*;
#(
  parameter int NUM_ENT = 24,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_lo,
  input  logic                     wr_hi,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     rd_hi,
  input  logic [WORD_W-1:0]        wdata,
  output logic [WORD_W-1:0]        rd_word,
  output logic [NUM_ENT*ENT_W-1:0] tbl_flat
);
  logic [ENT_W-1:0] mem [NUM_ENT];
  logic             lo_ok;

  assign lo_ok = wdata[MASK_BIT] || vec_legal(wdata[7:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_ENT; i++) mem[i] <= ENT_RESET;
    end else begin
      if (wr_hi) mem[idx][63:32] <= wdata;
      if (wr_lo && lo_ok) mem[idx][31:0] <= wdata;
    end
  end

  assign rd_word = rd_hi ? mem[idx][63:32] : mem[idx][31:0];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    assign tbl_flat[g*ENT_W +: ENT_W] = mem[g];

    a_r8_entry_reset: assert property (@(posedge clk)
      rst |=> (mem[g] == ENT_RESET));

    a_r6_filtered_keeps: assert property (@(posedge clk) disable iff (rst)
      (wr_lo && !lo_ok && idx == IDX_W'(g)) |=> $stable(mem[g]));

    a_r7_high_stored: assert property (@(posedge clk) disable iff (rst)
      (wr_hi && idx == IDX_W'(g)) |=> (mem[g][63:32] == $past(wdata)));
  end
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_ENT   = 24,
  parameter int CPU_COUNT = 1,
  localparam int IDX_W    = $clog2(NUM_ENT),
  localparam int TBL_W    = NUM_ENT * ENT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [TBL_W-1:0]  tbl_flat,
  output logic              ent_upd
);
  logic [7:0]       sel_q;
  logic [7:0]       id_q;
  logic             upd_q;
  logic             hit_sel, hit_win, is_id, is_ver, is_arb, ent_hit, ent_hi;
  logic [IDX_W-1:0] ent_idx;
  logic [31:0]      ent_word;
  logic             win_wr, ent_wr;

  irt_decode #(.NUM_ENT(NUM_ENT)) u_dec (
    .addr    (bus_addr[7:0]),
    .sel     (sel_q),
    .hit_sel (hit_sel),
    .hit_win (hit_win),
    .is_id   (is_id),
    .is_ver  (is_ver),
    .is_arb  (is_arb),
    .ent_hit (ent_hit),
    .ent_hi  (ent_hi),
    .ent_idx (ent_idx)
  );

  assign win_wr = bus_we && hit_win;
  assign ent_wr = win_wr && ent_hit;

  irt_table #(.NUM_ENT(NUM_ENT)) u_tbl (
    .clk      (clk),
    .rst      (rst),
    .wr_lo    (ent_wr && !ent_hi),
    .wr_hi    (ent_wr && ent_hi),
    .idx      (ent_idx),
    .rd_hi    (ent_hi),
    .wdata    (bus_wdata),
    .rd_word  (ent_word),
    .tbl_flat (tbl_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 8'h00;
      id_q  <= 8'(CPU_COUNT);
      upd_q <= 1'b0;
    end else begin
      if (bus_we && hit_sel) sel_q <= bus_wdata[7:0];
      if (win_wr && is_id)   id_q  <= bus_wdata[31:24];
      upd_q <= ent_wr;
    end
  end

  assign ent_upd = upd_q;

  always_comb begin
    bus_rdata = '0;
    if (hit_sel)
      bus_rdata = {24'h0, sel_q};
    else if (hit_win) begin
      if (is_id)        bus_rdata = {id_q, 24'h0};
      else if (is_ver)  bus_rdata = {8'h00, 8'(NUM_ENT - 1), 8'h00, VER_CODE};
      else if (is_arb)  bus_rdata = '0;
      else if (ent_hit) bus_rdata = ent_word;
    end
  end

  a_r8_sel_reset: assert property (@(posedge clk)
    rst |=> (sel_q == 8'h00));

  a_r9_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    ent_upd |-> $past(bus_we && bus_addr[7:0] == OFF_WIN && sel_q >= SEL_TBL
                      && ((sel_q - SEL_TBL) >> 1) < 8'(NUM_ENT)));

  a_r1_other_offset: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr[7:0] != OFF_SEL && bus_addr[7:0] != OFF_WIN)
      |=> ($stable(sel_q) && $stable(id_q) && $stable(tbl_flat)));

  a_r5_oob_select: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr[7:0] == OFF_WIN && sel_q >= SEL_TBL
       && ((sel_q - SEL_TBL) >> 1) >= 8'(NUM_ENT)) |=> $stable(tbl_flat));
endmodule

// File: tb/irq_route_regfile_tb.sv
module irq_route_regfile_tb;
  localparam int NE = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NE*64-1:0] tbl_flat;
  logic          ent_upd;
  logic          upd_seen;
  int            n_chk = 0;
  int            n_bad = 0;

  always #4 clk = ~clk;

  irq_route_regfile u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tbl_flat(tbl_flat),
    .ent_upd(ent_upd)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk); #1 upd_seen = ent_upd;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  function automatic logic [63:0] ent(input int i);
    return tbl_flat[i*64 +: 64];
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    rd(32'h00, d); chk("R8 select reset", d, 0);
    rd(32'h10, d); chk("R8 id reset", d, 32'h0100_0000);
    chk("R8 entry0 reset", ent(0), 64'h1_0000);
    chk("R8 entry23 reset", ent(NE-1), 64'h1_0000);
    chk("R9 strobe idle", ent_upd, 0);
  endtask

  task automatic t_id();
    logic [31:0] d;
    wr(32'h00, 32'h0000_0000);
    wr(32'h10, 32'hA512_3456);
    chk("R9 no strobe on id", upd_seen, 0);
    rd(32'h10, d); chk("R2 id keeps 31:24", d, 32'hA500_0000);
  endtask

  task automatic t_ver_arb();
    logic [31:0] d;
    wr(32'h00, 32'h01);
    rd(32'h00, d); chk("R1 select readback", d, 32'h01);
    rd(32'h10, d); chk("R3 version word", d, 32'h0017_0011);
    wr(32'h10, 32'hFFFF_FFFF);
    rd(32'h10, d); chk("R3 version write ignored", d, 32'h0017_0011);
    wr(32'h00, 32'h02);
    rd(32'h10, d); chk("R4 arb zero", d, 0);
    wr(32'h10, 32'hFFFF_FFFF);
    rd(32'h10, d); chk("R4 arb write ignored", d, 0);
  endtask

  task automatic t_entry();
    logic [31:0] d;
    wr(32'h00, 32'h1A);                 // entry 5 low
    wr(32'h10, 32'h0000_8030);
    chk("R9 strobe after entry write", upd_seen, 1);
    @(negedge clk); chk("R9 strobe one cycle", ent_upd, 0);
    rd(32'h10, d); chk("R5 entry5 low readback", d, 32'h0000_8030);
    wr(32'h00, 32'h1B);                 // entry 5 high
    wr(32'h10, 32'hFF00_0000);
    rd(32'h10, d); chk("R7 entry5 high readback", d, 32'hFF00_0000);
    chk("R10 entry5 on table", ent(5), 64'hFF00_0000_0000_8030);
    chk("R10 entry4 untouched", ent(4), 64'h1_0000);
    wr(32'h00, 32'h3F);                 // entry 23 high
    wr(32'h10, 32'h1234_5678);
    chk("R10 entry23 high", ent(23), 64'h1234_5678_0001_0000);
    wr(32'h00, 32'h10);                 // entry 0 low
    wr(32'h10, 32'h0000_00FE);
    chk("R6 vector FE accepted", ent(0), 64'h0000_00FE);
  endtask

  task automatic t_filter();
    wr(32'h00, 32'h1A);
    wr(32'h10, 32'h0000_0000);
    chk("R6 vector 00 dropped", ent(5), 64'hFF00_0000_0000_8030);
    chk("R9 strobe on dropped write", upd_seen, 1);
    wr(32'h10, 32'h0000_00FF);
    chk("R6 vector FF dropped", ent(5), 64'hFF00_0000_0000_8030);
    wr(32'h10, 32'h0000_000F);
    chk("R6 vector 0F dropped", ent(5), 64'hFF00_0000_0000_8030);
    wr(32'h10, 32'h0000_0010);
    chk("R6 vector 10 accepted", ent(5), 64'hFF00_0000_0000_0010);
    wr(32'h10, 32'h0001_0000);
    chk("R6 masked vector 00 accepted", ent(5), 64'hFF00_0000_0001_0000);
  endtask

  task automatic t_oob();
    logic [31:0] d;
    logic [NE*64-1:0] snap;
    snap = tbl_flat;
    wr(32'h00, 32'h40);
    rd(32'h10, d); chk("R5 past last entry reads 0", d, 0);
    wr(32'h10, 32'hDEAD_BEEF);
    chk("R9 no strobe out of range", upd_seen, 0);
    chk("R5 out of range write ignored", (tbl_flat == snap), 1);
    wr(32'h00, 32'h05);
    rd(32'h10, d); chk("R5 gap select reads 0", d, 0);
  endtask

  task automatic t_offsets();
    logic [31:0] d;
    logic [NE*64-1:0] snap;
    wr(32'h00, 32'h1B);
    snap = tbl_flat;
    wr(32'h04, 32'h0000_0011);
    rd(32'h04, d); chk("R1 other offset reads 0", d, 0);
    rd(32'h00, d); chk("R1 other offset write ignored", d, 32'h1B);
    chk("R1 table stable", (tbl_flat == snap), 1);
    rd(32'hFEC0_0110, d); chk("R1 upper address bits ignored", d, 32'hFF00_0000);
    // R11: read right after select write sees the new value
    wr(32'h100, 32'h1A);
    rd(32'h10, d); chk("R11 select effective next cycle", d, 32'h0001_0000);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_id();
    t_ver_arb();
    t_entry();
    t_filter();
    t_oob();
    t_offsets();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule